// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This unit watches the running calendar time supplied by a real time clock counter and raises a sticky alarm flag when the time agrees with a programmed alarm setting. Five alarm registers hold month, date, hour, minute and second in packed BCD. Bit 7 of each alarm register is a repeat mask. When that bit is set, the field is ignored in the compare. This lets the alarm fire once a year, once a month, once a day, once an hour, once a minute or once a second.

The compare is made only on the one-pulse-per-second tick from the clock counter. Software reads the flag through a byte-wide register port, and that read clears the flag.

The unit also drives an active-low, open-drain-style interrupt request. This line is shared with a watchdog request and with a frequency-test square wave. An alarm or a watchdog request always overrides the frequency test. A battery-mode input, together with a control enable, decides whether the alarm may drive the line while the system runs on backup power.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset:
  - `alarm_flag` is 0 and `irq_n` is 1.
  - The control register and every alarm register read as 0.
- R2: The alarm registers are at these addresses, and each reads back the byte last written:
  - Second at address 2.
  - Minute at 3.
  - Hour at 4.
  - Date at 5.
  - Month at 6.
- R2 (cont.): The control register is at address 1. Its bits are: bit 0 alarm interrupt enable, bit 1 battery-mode alarm enable, bit 2 frequency-test enable. Its upper bits read as 0.
- R3: On a cycle with `sec_tick` high, `alarm_flag` goes to 1 at the next clock edge when every unmasked field agrees with the time input. A field agrees when bits 6:0 of its register equal the matching byte of `time_bcd` in bits 6:0. The byte layout of `time_bcd` is month[39:32], date[31:24], hour[23:16], minute[15:8], second[7:0].
- R4: A field whose register has bit 7 set is a don't-care. With all five masked, the flag sets on every tick.
- R5: Without `sec_tick`, the flag is not set, even when the time matches.
- R6: The flag is sticky until read.
  - A read of address 0 returns the flag in bit 6, with all other bits 0.
  - In the cycle of the read, the returned bit is the current flag.
  - The flag is 0 from the following edge.
- R7: If a matching tick and a flag read fall in the same cycle, the flag stays 1.
- R8: A write to address 0 has no effect on the flag or on its read value.
- R9: `irq_n` is 0 when the flag is 1, the alarm interrupt enable is 1, and `on_battery` is 0. With the enable at 0, the alarm does not drive `irq_n`.
- R10: While `on_battery` is 1, the alarm drives `irq_n` only if the battery-mode alarm enable is 1.
- R11: `wdog_irq` high forces `irq_n` to 0 regardless of the control bits.
- R12: With frequency test enabled and no alarm or watchdog request, `irq_n` follows `ftest_wave`. An alarm or watchdog request overrides it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address |
| time_bcd | input | 40 | Current BCD time: month, date, hour, minute, second |
| sec_tick | input | 1 | One-cycle pulse once per second |
| on_battery | input | 1 | System is running from backup power |
| wdog_irq | input | 1 | Watchdog request routed to the shared line |
| ftest_wave | input | 1 | Frequency-test square wave |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low shared interrupt request (0 = pull low) |

## Verification
The alarm flag is registered. It changes at the first clock edge after the tick or the flag read that causes it. The bench therefore drives each stimulus on a falling edge and checks the flag on the next falling edge. `irq_n` and `reg_rdata` are combinational from the registered state and the inputs, so they are sampled one time unit after the inputs change within the same cycle. Stickiness is checked by waiting several idle cycles before looking at the flag again.

// File: rtl/cal_alarm_match.sv
module cal_alarm_match #(
  parameter int DW        = 8,
  parameter int AW        = 4,
  parameter int NF        = 5,
  parameter int FLAG_ADDR = 0,
  parameter int CTRL_ADDR = 1,
  parameter int ALM_BASE  = 2,
  parameter int AF_BIT    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NF*DW-1:0] time_bcd,
  input  logic             sec_tick,
  input  logic             on_battery,
  input  logic             wdog_irq,
  input  logic             ftest_wave,
  output logic             alarm_flag,
  output logic             irq_n
);
  localparam int MB = DW - 1;

  logic [DW-1:0] alm_q [NF];
  logic [NF-1:0] fld_hit;
  logic          ctl_afe, ctl_abe, ctl_ften, af_q;

  wire flag_rd = reg_re && (reg_addr == AW'(FLAG_ADDR));
  wire ctl_wr  = reg_we && (reg_addr == AW'(CTRL_ADDR));

  for (genvar gi = 0; gi < NF; gi++) begin : g_fld
    always_ff @(posedge clk) begin
      if (!rst_n)
        alm_q[gi] <= '0;
      else if (reg_we && reg_addr == AW'(ALM_BASE + gi))
        alm_q[gi] <= reg_wdata;
    end
    assign fld_hit[gi] = alm_q[gi][MB] ||
                         (alm_q[gi][MB-1:0] == time_bcd[gi*DW +: MB]);
  end

  wire hit = sec_tick && (&fld_hit);

  always_ff @(posedge clk) begin
    if (!rst_n)       af_q <= 1'b0;
    else if (hit)     af_q <= 1'b1;
    else if (flag_rd) af_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_afe  <= 1'b0;
      ctl_abe  <= 1'b0;
      ctl_ften <= 1'b0;
    end else if (ctl_wr) begin
      ctl_afe  <= reg_wdata[0];
      ctl_abe  <= reg_wdata[1];
      ctl_ften <= reg_wdata[2];
    end
  end

  wire alarm_drive = af_q && ctl_afe && (!on_battery || ctl_abe);

  assign alarm_flag = af_q;
  assign irq_n = (alarm_drive || wdog_irq) ? 1'b0 :
                 (ctl_ften ? ftest_wave : 1'b1);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(FLAG_ADDR))
      reg_rdata[AF_BIT] = af_q;
    else if (reg_addr == AW'(CTRL_ADDR))
      reg_rdata[2:0] = {ctl_ften, ctl_abe, ctl_afe};
    else
      for (int i = 0; i < NF; i++)
        if (reg_addr == AW'(ALM_BASE + i)) reg_rdata = alm_q[i];
  end
endmodule

module cal_alarm_match_chk #(
  parameter int AW        = 4,
  parameter int FLAG_ADDR = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_re,
  input logic [AW-1:0] reg_addr,
  input logic          sec_tick,
  input logic          on_battery,
  input logic          wdog_irq,
  input logic          ftest_wave,
  input logic          alarm_flag,
  input logic          irq_n,
  input logic          afe,
  input logic          abe,
  input logic          ften
);
  wire rd0 = reg_re && (reg_addr == AW'(FLAG_ADDR));

  AST_NO_SET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !alarm_flag) |=> !alarm_flag); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !rd0) |=> alarm_flag); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && !sec_tick) |=> !alarm_flag); // R6
  AST_ALARM_PULLS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && afe && !on_battery) |-> !irq_n); // R9
  AST_BATTERY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (on_battery && !abe && !wdog_irq && !ften) |-> irq_n); // R10
  AST_WDOG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_irq |-> !irq_n); // R11
  AST_FTEST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_flag && !wdog_irq && ften) |-> (irq_n == ftest_wave)); // R12
endmodule

bind cal_alarm_match cal_alarm_match_chk #(.AW(AW), .FLAG_ADDR(FLAG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_re(reg_re), .reg_addr(reg_addr),
  .sec_tick(sec_tick), .on_battery(on_battery), .wdog_irq(wdog_irq),
  .ftest_wave(ftest_wave), .alarm_flag(alarm_flag), .irq_n(irq_n),
  .afe(ctl_afe), .abe(ctl_abe), .ften(ctl_ften)
);

// File: tb/cal_alarm_match_bench.sv
module cal_alarm_match_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0, reg_re = 0;
  logic [3:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic [39:0] time_bcd = 0;
  logic        sec_tick = 0, on_battery = 0, wdog_irq = 0, ftest_wave = 0;
  logic        alarm_flag, irq_n;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  cal_alarm_match u_cal_alarm_match (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .time_bcd(time_bcd), .sec_tick(sec_tick), .on_battery(on_battery),
    .wdog_irq(wdog_irq), .ftest_wave(ftest_wave),
    .alarm_flag(alarm_flag), .irq_n(irq_n)
  );

  // {expected flag, month, date, hour, minute, second}; alarm = 06/15 xx:45:30, hour masked
  localparam logic [40:0] VEC [8] = '{
    {1'b1, 40'h06_15_12_45_30},
    {1'b1, 40'h06_15_23_45_30},
    {1'b0, 40'h06_15_12_45_31},
    {1'b0, 40'h07_15_12_45_30},
    {1'b0, 40'h06_14_12_45_30},
    {1'b0, 40'h06_15_00_44_30},
    {1'b1, 40'h06_15_09_45_30},
    {1'b0, 40'h12_31_12_45_30}
  };
  localparam logic [39:0] HIT = 40'h06_15_12_45_30;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_re = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic tick(logic [39:0] t);
    @(negedge clk); time_bcd = t; sec_tick = 1;
    @(negedge clk); sec_tick = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("R1 flag", alarm_flag, 0);
    chk("R1 irq", irq_n, 1);
    rst_n = 1;
    rd(4'd1, d); chk("R1 ctrl", d, 0);
    rd(4'd6, d); chk("R1 month", d, 0);

    wr(4'd2, 8'h30); wr(4'd3, 8'h45); wr(4'd4, 8'h92);
    wr(4'd5, 8'h15); wr(4'd6, 8'h06); wr(4'd1, 8'h01);
    rd(4'd2, d); chk("R2 second", d, 8'h30);
    rd(4'd4, d); chk("R2 hour", d, 8'h92);
    rd(4'd6, d); chk("R2 month", d, 8'h06);
    rd(4'd1, d); chk("R2 ctrl", d, 8'h01);

    wr(4'd0, 8'hFF);
    rd(4'd0, d); chk("R8 flag read", d, 0);
    chk("R8 flag", alarm_flag, 0);

    for (int i = 0; i < 8; i++) begin
      tick(VEC[i][39:0]);
      chk("R3/R4 vector flag", alarm_flag, VEC[i][40]);
      #1 chk("R9 irq", irq_n, !VEC[i][40]);
      rd(4'd0, d); chk("R6 read value", d, {1'b0, VEC[i][40], 6'b0});
      chk("R6 cleared", alarm_flag, 0);
    end

    @(negedge clk); time_bcd = HIT;
    repeat (3) @(negedge clk);
    chk("R5 no tick", alarm_flag, 0);

    tick(HIT);
    repeat (5) @(negedge clk);
    chk("R6 sticky", alarm_flag, 1);

    @(negedge clk); reg_re = 1; reg_addr = 0; sec_tick = 1; time_bcd = HIT;
    @(negedge clk); reg_re = 0; sec_tick = 0;
    chk("R7 tick beats read", alarm_flag, 1);

    on_battery = 1; #1 chk("R10 battery quiet", irq_n, 1);
    wr(4'd1, 8'h03); #1 chk("R10 battery enabled", irq_n, 0);
    on_battery = 0;
    wr(4'd1, 8'h00); #1 chk("R9 afe off", irq_n, 1);
    wdog_irq = 1; #1 chk("R11 watchdog", irq_n, 0);
    wdog_irq = 0;
    rd(4'd0, d);

    wr(4'd1, 8'h04);
    ftest_wave = 0; #1 chk("R12 ftest low", irq_n, 0);
    ftest_wave = 1; #1 chk("R12 ftest high", irq_n, 1);
    wdog_irq = 1; #1 chk("R12 watchdog over ftest", irq_n, 0);
    wdog_irq = 0;
    wr(4'd1, 8'h05); tick(HIT);
    #1 chk("R12 alarm over ftest", irq_n, 0);
    rd(4'd0, d);

    for (int a = 2; a <= 6; a++) wr(4'(a), 8'h80);
    tick(40'h01_02_03_04_05);
    chk("R4 all masked", alarm_flag, 1);
    rd(4'd0, d);
    tick(40'h11_22_23_59_58);
    chk("R4 all masked again", alarm_flag, 1);

    finish_run();
  end
endmodule